// File: doc/BRIEF.md
# Sync Polarity Normalizer and Display Mode Decoder

This block takes a horizontal (or composite) sync and a separate vertical sync as digital levels sampled on the system clock. Display sources send sync pulses of either polarity. For each input, the block counts how many samples in a fixed window are high. From that count it infers which level is the pulse, and it presents both syncs as active-high signals. When no separate vertical sync arrives, it takes vertical timing from the composite input instead. It does this by integrating long active stretches of the corrected composite sync.

The two inferred polarities together select one of four display modes. Three of these modes carry a fixed vertical amplitude preset. The fourth mode raises a flag that other logic can use to switch its own settings. A multi-frequency override input disables the presets and the flag, so downstream amplitude logic falls back to its nominal value.

Top module: `sync_mode_decoder`

## Requirements
- R1: A polarity flag (`hsync_neg`, `vsync_neg`) reads 1 when the input's pulses are low-going and 0 when they are high-going. This holds for pulses up to 30% of the window. A flag is set when more than WINDOW/2+HYST of the window's samples are high, and cleared when fewer than WINDOW/2-HYST are high.
- R2: When a window's high count lies within WINDOW/2±HYST inclusive, the polarity flag keeps its previous value.
- R3: After the input polarity reverses, the flag takes the new value within 2·WINDOW+SYNC_STAGES+2 clock cycles.
- R4: `hsync_out` and the separate-vertical path of `vsync_out` are the input level XOR the polarity flag. They lag the input by SYNC_STAGES cycles, so they are 1 during a pulse of either polarity.
- R5: `mode` decodes the horizontal/vertical polarities as follows: positive/negative gives 0 (350-line), negative/positive gives 1 (400-line), negative/negative gives 2 (480-line), and positive/positive gives 3 (external mode). The output is registered one cycle after the polarity flags.
- R6: `fourth_mode` is 1 only when `mode` is 3 and the override is low.
- R7: While `multi_freq` is 1, `preset_en` is 0 and `preset_amp` is 1000.
- R8: With the override low, `preset_en` is 1. `preset_amp`, in tenths of a percent, is 1168 in mode 0, 1022 in mode 1, and 1000 in modes 2 and 3.
- R9: When the composite source is selected, `vsync_out` rises once the corrected composite sync has been continuously active for INTEG_CYCLES cycles. It falls one cycle after the corrected composite sync goes inactive. Shorter pulses never produce it.
- R10: `vsync_from_comp` goes to 1 once VS_TIMEOUT cycles pass with no rising edge of the corrected separate vertical sync. It returns to 0 on the cycle after such an edge.
- R11: In reset, both polarity flags are 0, `mode` is 3, `fourth_mode` and `preset_en` are 0, `preset_amp` is 1000, and `vsync_from_comp` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_raw | input | 1 | Horizontal or composite sync, any polarity |
| vsync_raw | input | 1 | Separate vertical sync, any polarity; tie low when unused |
| multi_freq | input | 1 | Override: disable mode presets and the fourth-mode flag |
| hsync_out | output | 1 | Active-high corrected horizontal sync |
| vsync_out | output | 1 | Active-high vertical sync from the selected source |
| hsync_neg | output | 1 | 1 when horizontal pulses are low-going |
| vsync_neg | output | 1 | 1 when vertical pulses are low-going |
| vsync_from_comp | output | 1 | 1 when vertical sync comes from composite integration |
| mode | output | 2 | Decoded display mode, 0 to 3 |
| fourth_mode | output | 1 | High in mode 3 without override |
| preset_en | output | 1 | Amplitude preset valid |
| preset_amp | output | AMP_W | Amplitude preset in tenths of a percent |

## Verification
All four polarity pairings are driven, each with the override both low and high. This separates the mode decode, the flag gating and each amplitude preset. Duty cycles of 20%, 30% and 50% show that the detector tells pulse level apart from idle level, and that it holds its decision in the ambiguous band. A removed vertical sync exposes the fallback timer, and a reconnected one exposes the return. Forced composite stretches just shorter and well longer than the integration length tell a real vertical interval apart from an ordinary line pulse.

// File: rtl/sdec_pkg.sv
package sdec_pkg;

   typedef enum logic [1:0] {
      MODE_350 = 2'd0,
      MODE_400 = 2'd1,
      MODE_480 = 2'd2,
      MODE_EXT = 2'd3
   } disp_mode_e;

   // horizontal flag first, vertical flag second; 1 means low-going pulses
   function automatic disp_mode_e decode_mode(input logic h_neg, input logic v_neg);
      case ({h_neg, v_neg})
         2'b01:   return MODE_350;
         2'b10:   return MODE_400;
         2'b11:   return MODE_480;
         default: return MODE_EXT;
      endcase
   endfunction

endpackage

// File: rtl/sdec_polarity.sv
module sdec_polarity #(
   parameter int SYNC_STAGES = 2,
   parameter int WINDOW      = 4096,
   parameter int HYST        = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_in,
   output logic neg_pol,
   output logic corrected
);
   localparam int CW    = $clog2(WINDOW + 1);
   localparam int MID   = WINDOW / 2;
   localparam int HI_TH = MID + HYST;
   localparam int LO_TH = MID - HYST;
   localparam logic [CW-1:0] HI_V  = CW'(HI_TH);
   localparam logic [CW-1:0] LO_V  = CW'(LO_TH);
   localparam logic [CW-1:0] END_V = CW'(WINDOW - 1);

   if (WINDOW < 8) begin : g_bad_window
      $error("sdec_polarity: WINDOW too small");
   end
   if (HYST < 1 || HYST * 5 > WINDOW) begin : g_bad_hyst
      $error("sdec_polarity: HYST must be in 1..WINDOW/5");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_stages
      $error("sdec_polarity: SYNC_STAGES out of range");
   end

   logic smp;

   if (SYNC_STAGES == 0) begin : g_direct
      assign smp = raw_in;
   end else if (SYNC_STAGES == 1) begin : g_one
      logic q1;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q1 <= 1'b0;
         else        q1 <= raw_in;
      end
      assign smp = q1;
   end else begin : g_chain
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[SYNC_STAGES-2:0], raw_in};
      end
      assign smp = sh[SYNC_STAGES-1];
   end

   logic [CW-1:0] win_cnt;
   logic [CW-1:0] hi_cnt;
   logic [CW-1:0] total;
   logic          win_end;
   logic          neg_q;

   assign win_end = (win_cnt == END_V);
   assign total   = hi_cnt + CW'(smp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt <= '0;
         hi_cnt  <= '0;
         neg_q   <= 1'b0;
      end else if (win_end) begin
         win_cnt <= '0;
         hi_cnt  <= '0;
         if (total > HI_V)      neg_q <= 1'b1;
         else if (total < LO_V) neg_q <= 1'b0;
      end else begin
         win_cnt <= win_cnt + 1'b1;
         hi_cnt  <= total;
      end
   end

   assign neg_pol   = neg_q;
   assign corrected = smp ^ neg_q;

   p_set_neg_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && total > HI_V) |=> neg_pol);
   p_set_pos_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && total < LO_V) |=> !neg_pol);
   p_hyst_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && total >= LO_V && total <= HI_V) |=> $stable(neg_pol));
   p_only_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end |=> $stable(neg_pol));

endmodule

// File: rtl/sdec_vinteg.sv
module sdec_vinteg #(
   parameter int INTEG_CYCLES = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic comp_act,
   output logic vs_int
);
   localparam int IW = $clog2(INTEG_CYCLES + 1);
   localparam logic [IW-1:0] LIM = IW'(INTEG_CYCLES);

   if (INTEG_CYCLES < 2) begin : g_bad_integ
      $error("sdec_vinteg: INTEG_CYCLES must be at least 2");
   end

   logic [IW-1:0] acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           acc <= '0;
      else if (!comp_act)   acc <= '0;
      else if (acc != LIM)  acc <= acc + 1'b1;
   end

   assign vs_int = (acc == LIM);

   p_needs_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vs_int) |-> $past(comp_act));
   p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !comp_act |=> !vs_int);

endmodule

// File: rtl/sdec_vsel.sv
module sdec_vsel #(
   parameter int VS_TIMEOUT = 1250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vsep,
   input  logic vint,
   output logic use_int,
   output logic vs_out
);
   localparam int TW = $clog2(VS_TIMEOUT + 1);
   localparam logic [TW-1:0] TMO = TW'(VS_TIMEOUT);

   if (VS_TIMEOUT < 4) begin : g_bad_tmo
      $error("sdec_vsel: VS_TIMEOUT too small");
   end

   logic [TW-1:0] tmr;
   logic          vsep_d;
   logic          rise;
   logic          use_q;

   assign rise = vsep & ~vsep_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr    <= '0;
         vsep_d <= 1'b0;
         use_q  <= 1'b1;
      end else begin
         vsep_d <= vsep;
         if (rise) begin
            tmr   <= '0;
            use_q <= 1'b0;
         end else if (tmr == TMO) begin
            use_q <= 1'b1;
         end else begin
            tmr <= tmr + 1'b1;
         end
      end
   end

   assign use_int = use_q;
   assign vs_out  = use_q ? vint : vsep;

   p_fallback_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr == TMO && !rise) |=> use_int);
   p_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !use_int);

endmodule

// File: rtl/sdec_mode.sv
module sdec_mode
   import sdec_pkg::*;
#(
   parameter int AMP_W   = 11,
   parameter int AMP_M1  = 1168,
   parameter int AMP_M2  = 1022,
   parameter int AMP_NOM = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             h_neg,
   input  logic             v_neg,
   input  logic             mf,
   output disp_mode_e       mode,
   output logic             fourth,
   output logic             preset_en,
   output logic [AMP_W-1:0] amp
);
   if (AMP_M1 >= (1 << AMP_W) || AMP_M2 >= (1 << AMP_W) || AMP_NOM >= (1 << AMP_W))
   begin : g_bad_amp
      $error("sdec_mode: preset value exceeds AMP_W");
   end

   localparam logic [AMP_W-1:0] A1 = AMP_W'(AMP_M1);
   localparam logic [AMP_W-1:0] A2 = AMP_W'(AMP_M2);
   localparam logic [AMP_W-1:0] AN = AMP_W'(AMP_NOM);

   disp_mode_e       mode_d;
   logic [AMP_W-1:0] amp_d;

   always_comb begin
      mode_d = decode_mode(h_neg, v_neg);
      if (mf) begin
         amp_d = AN;
      end else begin
         case (mode_d)
            MODE_350: amp_d = A1;
            MODE_400: amp_d = A2;
            default:  amp_d = AN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode      <= MODE_EXT;
         fourth    <= 1'b0;
         preset_en <= 1'b0;
         amp       <= AN;
      end else begin
         mode      <= mode_d;
         fourth    <= (mode_d == MODE_EXT) && !mf;
         preset_en <= !mf;
         amp       <= amp_d;
      end
   end

   p_flag_only_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fourth |-> (mode == MODE_EXT));
   p_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mf |=> (!preset_en && amp == AN && !fourth));
   p_decode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (h_neg && !v_neg) |=> (mode == MODE_400));
   p_amp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mf && !h_neg && v_neg) |=> (preset_en && amp == A1));

endmodule

// File: rtl/sync_mode_decoder.sv
module sync_mode_decoder
   import sdec_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int H_WINDOW     = 4096,
   parameter int H_HYST       = 512,
   parameter int V_WINDOW     = 1000000,
   parameter int V_HYST       = 100000,
   parameter int INTEG_CYCLES = 500,
   parameter int VS_TIMEOUT   = 1250000,
   parameter int AMP_W        = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync_raw,
   input  logic             vsync_raw,
   input  logic             multi_freq,
   output logic             hsync_out,
   output logic             vsync_out,
   output logic             hsync_neg,
   output logic             vsync_neg,
   output logic             vsync_from_comp,
   output logic [1:0]       mode,
   output logic             fourth_mode,
   output logic             preset_en,
   output logic [AMP_W-1:0] preset_amp
);
   if (VS_TIMEOUT <= V_WINDOW / 2) begin : g_bad_timeout
      $error("sync_mode_decoder: VS_TIMEOUT must exceed half the vertical window");
   end

   logic       h_corr;
   logic       v_corr;
   logic       v_int;
   disp_mode_e mode_e;

   sdec_polarity #(
      .SYNC_STAGES (SYNC_STAGES),
      .WINDOW      (H_WINDOW),
      .HYST        (H_HYST)
   ) u_hpol (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_in    (hsync_raw),
      .neg_pol   (hsync_neg),
      .corrected (h_corr)
   );

   sdec_polarity #(
      .SYNC_STAGES (SYNC_STAGES),
      .WINDOW      (V_WINDOW),
      .HYST        (V_HYST)
   ) u_vpol (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_in    (vsync_raw),
      .neg_pol   (vsync_neg),
      .corrected (v_corr)
   );

   sdec_vinteg #(
      .INTEG_CYCLES (INTEG_CYCLES)
   ) u_integ (
      .clk      (clk),
      .rst_n    (rst_n),
      .comp_act (h_corr),
      .vs_int   (v_int)
   );

   sdec_vsel #(
      .VS_TIMEOUT (VS_TIMEOUT)
   ) u_vsel (
      .clk     (clk),
      .rst_n   (rst_n),
      .vsep    (v_corr),
      .vint    (v_int),
      .use_int (vsync_from_comp),
      .vs_out  (vsync_out)
   );

   sdec_mode #(
      .AMP_W (AMP_W)
   ) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .h_neg     (hsync_neg),
      .v_neg     (vsync_neg),
      .mf        (multi_freq),
      .mode      (mode_e),
      .fourth    (fourth_mode),
      .preset_en (preset_en),
      .amp       (preset_amp)
   );

   assign hsync_out = h_corr;
   assign mode      = mode_e;

   p_corr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!vsync_from_comp) |-> (vsync_out == v_corr));

endmodule

// File: tb/sync_mode_decoder_tb_top.sv
module sync_mode_decoder_tb_top;
   localparam int ST   = 2;
   localparam int HWIN = 100;
   localparam int HHY  = 10;
   localparam int VWIN = 400;
   localparam int VHY  = 40;
   localparam int INTG = 20;
   localparam int TMO  = 1500;
   localparam int HP   = 50;
   localparam int VP   = 200;
   localparam int VWP  = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hsync_raw = 1'b0;
   logic vsync_raw = 1'b0;
   logic multi_freq = 1'b0;
   logic hsync_out, vsync_out, hsync_neg, vsync_neg, vsync_from_comp;
   logic [1:0] mode;
   logic fourth_mode, preset_en;
   logic [10:0] preset_amp;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int h_phase = 0, v_phase = 0;
   int h_w = 10;
   bit h_neg_s = 0, v_neg_s = 0, v_en = 1, h_force = 0, h_fval = 0;

   always #10 clk = ~clk;

   sync_mode_decoder #(
      .SYNC_STAGES (ST), .H_WINDOW (HWIN), .H_HYST (HHY),
      .V_WINDOW (VWIN), .V_HYST (VHY), .INTEG_CYCLES (INTG),
      .VS_TIMEOUT (TMO), .AMP_W (11)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .hsync_raw (hsync_raw), .vsync_raw (vsync_raw),
      .multi_freq (multi_freq), .hsync_out (hsync_out), .vsync_out (vsync_out),
      .hsync_neg (hsync_neg), .vsync_neg (vsync_neg), .vsync_from_comp (vsync_from_comp),
      .mode (mode), .fourth_mode (fourth_mode), .preset_en (preset_en),
      .preset_amp (preset_amp)
   );

   // stimulus generators, updated just after each rising edge
   always begin
      @(posedge clk);
      #1;
      h_phase = (h_phase == HP - 1) ? 0 : h_phase + 1;
      v_phase = (v_phase == VP - 1) ? 0 : v_phase + 1;
      hsync_raw = h_force ? h_fval : ((h_phase < h_w) ^ h_neg_s);
      vsync_raw = v_en ? ((v_phase < VWP) ^ v_neg_s) : 1'b0;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_hphase(input int p);
      do @(negedge clk); while (h_phase != p);
   endtask

   task automatic wait_vphase(input int p);
      do @(negedge clk); while (v_phase != p);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // {h_neg, v_neg, mf, mode[1:0], fourth, en, amp[10:0]}
   localparam logic [17:0] VEC [0:7] = '{
      {1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 11'd1168},
      {1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 11'd1022},
      {1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 1'b1, 11'd1000},
      {1'b0, 1'b0, 1'b0, 2'd3, 1'b1, 1'b1, 11'd1000},
      {1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 11'd1000},
      {1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 11'd1000},
      {1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 11'd1000},
      {1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 11'd1000}
   };

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int vmax;
      // R11 reset state
      wait_cyc(3);
      chk("R11 hsync_neg", hsync_neg, 0);
      chk("R11 vsync_neg", vsync_neg, 0);
      chk("R11 mode", mode, 3);
      chk("R11 fourth_mode", fourth_mode, 0);
      chk("R11 preset_en", preset_en, 0);
      chk("R11 preset_amp", preset_amp, 1000);
      chk("R11 vsync_from_comp", vsync_from_comp, 1);
      rst_n = 1'b1;

      // table walk: R1 R4 R5 R6 R7 R8
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         h_neg_s    = VEC[i][17];
         v_neg_s    = VEC[i][16];
         multi_freq = VEC[i][15];
         wait_cyc(3 * VWIN + 20);
         chk("R1 hsync_neg", hsync_neg, VEC[i][17]);
         chk("R1 vsync_neg", vsync_neg, VEC[i][16]);
         chk("R5 mode", mode, VEC[i][14:13]);
         chk("R6 fourth_mode", fourth_mode, VEC[i][12]);
         chk("R7 preset_en", preset_en, VEC[i][11]);
         chk("R8 preset_amp", preset_amp, VEC[i][10:0]);
         wait_hphase(h_w / 2);
         chk("R4 hsync_out in pulse", hsync_out, 1);
         wait_hphase((HP + h_w) / 2);
         chk("R4 hsync_out idle", hsync_out, 0);
         wait_vphase(VWP / 2);
         chk("R4 vsync_out in pulse", vsync_out, 1);
         wait_vphase(VP / 2);
         chk("R4 vsync_out idle", vsync_out, 0);
      end
      multi_freq = 1'b0;

      // R3 polarity reversal latency (currently positive)
      @(negedge clk);
      h_neg_s = 1;
      wait_cyc(2 * HWIN + ST + 2);
      chk("R3 flip to negative", hsync_neg, 1);

      // R2 hysteresis: 50% duty holds the previous decision
      h_w = 25; h_neg_s = 0;
      wait_cyc(4 * HWIN);
      chk("R2 hold negative", hsync_neg, 1);
      h_w = 10;
      wait_cyc(3 * HWIN);
      chk("R1 back to positive", hsync_neg, 0);
      h_w = 25;
      wait_cyc(4 * HWIN);
      chk("R2 hold positive", hsync_neg, 0);

      // R1 30% boundary
      h_w = 15; h_neg_s = 1;
      wait_cyc(3 * HWIN);
      chk("R1 30pct low-going", hsync_neg, 1);
      h_neg_s = 0;
      wait_cyc(3 * HWIN);
      chk("R1 30pct high-going", hsync_neg, 0);
      h_w = 10;

      // R10 fallback after vertical sync disappears
      v_en = 0;
      wait_cyc(100);
      chk("R10 not yet fallen back", vsync_from_comp, 0);
      wait_cyc(TMO + 2 * VP + 50);
      chk("R10 fallback", vsync_from_comp, 1);

      // R9 ordinary line pulses never make vertical sync
      vmax = 0;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (vsync_out) vmax = 1;
      end
      chk("R9 line pulses ignored", vmax, 0);

      // R9 stretch shorter than the integration length
      wait_hphase(25);
      h_fval = 1; h_force = 1;
      vmax = 0;
      for (int k = 0; k < 15 + ST + 2; k++) begin
         @(negedge clk);
         if (k == 14) h_force = 0;
         if (vsync_out) vmax = 1;
      end
      chk("R9 short stretch ignored", vmax, 0);

      // R9 long stretch produces vertical sync, then drops
      wait_hphase(12);
      h_force = 1;
      wait_cyc(30);
      chk("R9 long stretch", vsync_out, 1);
      wait_cyc(4);
      h_force = 0;
      wait_cyc(ST + 3);
      chk("R9 drops after stretch", vsync_out, 0);

      // R10 return on a separate vertical edge
      v_neg_s = 0; v_en = 1;
      wait_cyc(VP + 20);
      chk("R10 return to separate", vsync_from_comp, 0);

      finish_run();
   end
endmodule